// File: doc/BRIEF.md
# Pin Input Capture Cell Array

This block sits between a row of device pins and a programmable logic array. Each cell takes one pin value and hands it to the array in both true and inverted polarity. A cell can capture its value in one of three ways: as an edge register that loads on a rising edge of the shared input-cell clock, as a level latch that is open while that clock is high, or as a straight wire that skips storage altogether. Two configuration bits per cell pick the way. The capture mode names used in the design are CAP_REG, CAP_LATCH and CAP_PASS.

The first `N_IN` cells serve input-only pins. The next `N_IO` cells serve bidirectional pins. For each bidirectional cell, a logic cell supplies output data and a full sum-of-products output enable, and the block passes both to the pad driver. The capture path of a bidirectional cell reads either the pad's received value or a feedback signal from that logic cell, as a per-cell select bit decides.

The shared input-cell clock is sampled on the system clock `clk`. One tracker state machine has two states, PH_LOW and PH_HIGH. Reset puts it in PH_LOW. The transition PH_LOW to PH_HIGH happens at an edge where the cell clock is sampled high, and that same cycle raises the capture strobe for register cells. The transition PH_HIGH to PH_LOW happens when the cell clock is sampled low. In every other cycle the state stays where it is.

Top module: `incell_array`

## Requirements
- R1: With `cfg_bypass`=0 and `cfg_latch`=0, a cell stores its source at a `clk` rising edge where `cell_clk` is sampled high and the tracker is in PH_LOW. Its array output shows that stored value from that edge until the next such edge.
- R2: With `cfg_bypass`=0 and `cfg_latch`=1, a cell's array output follows its source combinationally while `cell_clk` is high. While `cell_clk` is low, the output holds the source value present at the last `clk` edge that sampled `cell_clk` high.
- R3: With `cfg_bypass`=1, a cell's array output equals its source at all times, whatever `cell_clk` does.
- R4: A bypassed cell does not update its stored value. When bypass is cleared, the cell shows the value it held before bypass was set, until its next capture.
- R5: A synchronous `rst` clears every stored value to 0 and returns the tracker to PH_LOW. A `cell_clk` that is already high on the first sample after reset therefore counts as a rising edge.
- R6: `arr_comp` is always the bitwise inverse of `arr_true`.
- R7: For each bidirectional cell k, `io_pad_out[k]` equals `lc_out[k]` and `io_pad_oe[k]` equals `lc_oe[k]`, whatever the capture configuration.
- R8: For bidirectional cell k, `cfg_src[k]`=0 selects `io_pad_in[k]` as the capture source and `cfg_src[k]`=1 selects `lc_fb[k]`.
- R9: Array bit i, for i below `N_IN`, serves `in_pin[i]`. Array bit `N_IN`+k serves bidirectional cell k.
- R10: Each cell's mode and source select act on that cell alone. Cells in different modes share one `cell_clk` without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples `cell_clk` and updates stored values |
| rst | input | 1 | Synchronous reset, active high |
| cell_clk | input | 1 | Global input-cell capture clock |
| cfg_bypass | input | N_IN+N_IO | Per-cell bypass select (1 = pass-through) |
| cfg_latch | input | N_IN+N_IO | Per-cell storage type (1 = latch, 0 = register) |
| cfg_src | input | N_IO | Per bidirectional cell capture source (0 = pad, 1 = feedback) |
| in_pin | input | N_IN | Received values of input-only pins |
| io_pad_in | input | N_IO | Received values of bidirectional pads |
| lc_out | input | N_IO | Output data from the driving logic cells |
| lc_oe | input | N_IO | Sum-of-products output enables from the logic cells |
| lc_fb | input | N_IO | Feedback selections from the logic cells |
| io_pad_out | output | N_IO | Data to the bidirectional pad drivers |
| io_pad_oe | output | N_IO | Driver enables; 0 releases the pad to high impedance |
| arr_true | output | N_IN+N_IO | Captured values to the array, true polarity |
| arr_comp | output | N_IN+N_IO | Captured values to the array, inverted polarity |

## Verification
A tracker left in the wrong phase shows up as a register cell that loads one clock early, loads twice in one cell-clock high period, or misses a load. The bit on `arr_true` then disagrees on the very next sampled cycle. A wrong stored bit is visible at once in register mode. In latch mode it surfaces on the first cycle `cell_clk` is low. In bypass it stays hidden until bypass is cleared, so the stimulus toggles bypass at random and compares the first cycle after each exit. A reference model of every cell is compared against every output once per clock, so a wrong state is reported within one cycle of reaching a port.

// File: rtl/incell_pkg.sv
package incell_pkg;

    typedef enum logic [1:0] {
        CAP_REG   = 2'd0,
        CAP_LATCH = 2'd1,
        CAP_PASS  = 2'd2
    } cap_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } clk_phase_e;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_FB  = 1'b1
    } cap_src_e;

endpackage

// File: rtl/incell_clk_tracker.sv
module incell_clk_tracker
    import incell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cell_clk_i,
    output logic rise_o,
    output logic high_o
);

    clk_phase_e state_q;
    clk_phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (cell_clk_i)  state_d = PH_HIGH;
            PH_HIGH: if (!cell_clk_i) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            PH_LOW:  rise_o = cell_clk_i;
            PH_HIGH: rise_o = 1'b0;
            default: rise_o = 1'b0;
        endcase
        high_o = cell_clk_i;
    end

    // R1: a fresh high sample of the cell clock yields a capture strobe
    assert_rise_on_edge_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(cell_clk_i) |-> rise_o);

    // R1: at most one strobe per high period
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/incell_capture.sv
module incell_capture
    import incell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    input  logic high_i,
    input  logic bypass_i,
    input  logic latch_i,
    input  logic d_i,
    output logic q_o
);

    cap_mode_e mode;
    logic      store_q;
    logic      load;

    always_comb begin
        if (bypass_i)     mode = CAP_PASS;
        else if (latch_i) mode = CAP_LATCH;
        else              mode = CAP_REG;
    end

    always_comb begin
        load = 1'b0;
        unique case (mode)
            CAP_REG:   load = rise_i;
            CAP_LATCH: load = high_i;
            CAP_PASS:  load = 1'b0;
            default:   load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       store_q <= 1'b0;
        else if (load) store_q <= d_i;
    end

    always_comb begin
        q_o = store_q;
        unique case (mode)
            CAP_PASS:  q_o = d_i;
            CAP_LATCH: q_o = high_i ? d_i : store_q;
            CAP_REG:   q_o = store_q;
            default:   q_o = store_q;
        endcase
    end

    // R1: register mode shows the value present at the capturing edge
    assert_reg_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_REG && rise_i) |=> (mode != CAP_REG || q_o == $past(d_i)));

    // R2: a closed latch keeps its output steady
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_LATCH && !high_i) |=> (mode != CAP_LATCH || high_i || $stable(q_o)));

    // R4: bypass leaves the stored value untouched
    assert_bypass_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_PASS) |=> $stable(store_q));

    // R5: storage is empty on leaving reset
    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (store_q == 1'b0));

endmodule

// File: rtl/incell_io_lane.sv
module incell_io_lane
    import incell_pkg::*;
(
    input  logic pad_in_i,
    input  logic lc_out_i,
    input  logic lc_oe_i,
    input  logic lc_fb_i,
    input  logic src_sel_i,
    output logic cap_src_o,
    output logic pad_out_o,
    output logic pad_oe_o
);

    cap_src_e src;

    always_comb begin
        src = cap_src_e'(src_sel_i);
        unique case (src)
            SRC_PIN: cap_src_o = pad_in_i;
            SRC_FB:  cap_src_o = lc_fb_i;
            default: cap_src_o = pad_in_i;
        endcase
    end

    always_comb begin
        pad_out_o = lc_out_i;
        pad_oe_o  = lc_oe_i;
    end

endmodule

// File: rtl/incell_array.sv
module incell_array
    import incell_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_IO = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cell_clk,
    input  logic [N_IN+N_IO-1:0] cfg_bypass,
    input  logic [N_IN+N_IO-1:0] cfg_latch,
    input  logic [N_IO-1:0]      cfg_src,
    input  logic [N_IN-1:0]      in_pin,
    input  logic [N_IO-1:0]      io_pad_in,
    input  logic [N_IO-1:0]      lc_out,
    input  logic [N_IO-1:0]      lc_oe,
    input  logic [N_IO-1:0]      lc_fb,
    output logic [N_IO-1:0]      io_pad_out,
    output logic [N_IO-1:0]      io_pad_oe,
    output logic [N_IN+N_IO-1:0] arr_true,
    output logic [N_IN+N_IO-1:0] arr_comp
);

    localparam int NC = N_IN + N_IO;

    logic          rise;
    logic          high;
    logic [NC-1:0] src_all;
    logic [NC-1:0] q_all;

    incell_clk_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .cell_clk_i(cell_clk),
        .rise_o    (rise),
        .high_o    (high)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in_src
        assign src_all[i] = in_pin[i];
    end

    for (genvar k = 0; k < N_IO; k++) begin : g_io_lane
        incell_io_lane u_lane (
            .pad_in_i (io_pad_in[k]),
            .lc_out_i (lc_out[k]),
            .lc_oe_i  (lc_oe[k]),
            .lc_fb_i  (lc_fb[k]),
            .src_sel_i(cfg_src[k]),
            .cap_src_o(src_all[N_IN+k]),
            .pad_out_o(io_pad_out[k]),
            .pad_oe_o (io_pad_oe[k])
        );
    end

    for (genvar c = 0; c < NC; c++) begin : g_cell
        incell_capture u_cap (
            .clk     (clk),
            .rst     (rst),
            .rise_i  (rise),
            .high_i  (high),
            .bypass_i(cfg_bypass[c]),
            .latch_i (cfg_latch[c]),
            .d_i     (src_all[c]),
            .q_o     (q_all[c])
        );
    end

    always_comb begin
        arr_true = q_all;
        arr_comp = ~q_all;
    end

endmodule

// File: tb/incell_array_tb_top.sv
module incell_array_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 4;
    localparam int N_IO = 4;
    localparam int NC   = N_IN + N_IO;

    logic            clk = 1'b0;
    logic            rst;
    logic            cell_clk;
    logic [NC-1:0]   cfg_bypass, cfg_latch;
    logic [N_IO-1:0] cfg_src, io_pad_in, lc_out, lc_oe, lc_fb;
    logic [N_IN-1:0] in_pin;
    logic [N_IO-1:0] io_pad_out, io_pad_oe;
    logic [NC-1:0]   arr_true, arr_comp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit [NC-1:0] m_store = '0;
    bit          m_prev  = 0;
    bit          bypass_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    incell_array #(.N_IN(N_IN), .N_IO(N_IO)) dut_i (
        .clk(clk), .rst(rst), .cell_clk(cell_clk),
        .cfg_bypass(cfg_bypass), .cfg_latch(cfg_latch), .cfg_src(cfg_src),
        .in_pin(in_pin), .io_pad_in(io_pad_in), .lc_out(lc_out), .lc_oe(lc_oe),
        .lc_fb(lc_fb), .io_pad_out(io_pad_out), .io_pad_oe(io_pad_oe),
        .arr_true(arr_true), .arr_comp(arr_comp)
    );

    task automatic check_bit(string req, int idx, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cell %0d actual=%b expected=%b t=%0t", req, idx, act, exp, $time);
        end
    endtask

    // R8 R9: source of each cell as the requirements define it
    function automatic bit src_of(int i);
        if (i < N_IN) return in_pin[i];
        return cfg_src[i-N_IN] ? lc_fb[i-N_IN] : io_pad_in[i-N_IN];
    endfunction

    function automatic bit exp_of(int i);
        if (cfg_bypass[i]) return src_of(i);
        if (cfg_latch[i])  return cell_clk ? src_of(i) : m_store[i];
        return m_store[i];
    endfunction

    task automatic compare(string force_tag);
        for (int i = 0; i < NC; i++) begin
            string tag;
            if (force_tag != "")    tag = force_tag;
            else if (cfg_bypass[i]) tag = bypass_phase ? "R4" : "R3";
            else if (cfg_latch[i])  tag = "R2";
            else                    tag = "R1";
            if (i >= N_IN) tag = {tag, " R8 R9 R10"};
            check_bit(tag, i, arr_true[i], exp_of(i));
            check_bit("R6", i, arr_comp[i], ~arr_true[i]);
        end
        for (int k = 0; k < N_IO; k++) begin
            check_bit("R7 out", k, io_pad_out[k], lc_out[k]);
            check_bit("R7 oe",  k, io_pad_oe[k],  lc_oe[k]);
        end
    endtask

    // inputs already driven at the falling edge; check, then advance model
    task automatic cycle(bit do_check, string force_tag);
        #1;
        if (do_check) compare(force_tag);
        @(posedge clk);
        if (rst) begin
            m_store = '0;
            m_prev  = 0;
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (!cfg_bypass[i]) begin
                    if (cfg_latch[i] ? cell_clk : (cell_clk && !m_prev))
                        m_store[i] = src_of(i);
                end
            end
            m_prev = cell_clk;
        end
        @(negedge clk);
    endtask

    task automatic rand_data();
        in_pin    = N_IN'($urandom);
        io_pad_in = N_IO'($urandom);
        lc_out    = N_IO'($urandom);
        lc_oe     = N_IO'($urandom);
        lc_fb     = N_IO'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int hold;
        rst = 1'b1; cell_clk = 1'b1;
        cfg_bypass = '0; cfg_latch = '0; cfg_src = '0;
        in_pin = '1; io_pad_in = '1; lc_out = '0; lc_oe = '0; lc_fb = '1;
        @(negedge clk);
        cycle(0, "");
        cycle(1, "R5");
        cycle(1, "R5");
        // release with cell_clk already high: first sample counts as an edge (R5)
        rst = 1'b0;
        cycle(1, "R5");
        cycle(1, "R5");

        hold = 0;
        for (int ph = 0; ph < 8; ph++) begin
            cfg_bypass   = (ph == 0) ? '0 : NC'($urandom);
            cfg_latch    = NC'($urandom);
            cfg_src      = N_IO'($urandom);
            bypass_phase = (ph == 5);
            for (int n = 0; n < 250; n++) begin
                rand_data();
                if (hold == 0) begin
                    cell_clk = ~cell_clk;
                    hold = (ph == 6) ? 0 : int'($urandom_range(0, 4));
                end else begin
                    hold--;
                end
                if (bypass_phase) cfg_bypass = NC'($urandom);
                if (ph == 7) rst = ($urandom_range(0, 40) == 0);
                cycle(1, "");
            end
            rst = 1'b0;
        end

        // directed R4: bypass over a stored value, then reveal it
        cfg_bypass = '0; cfg_latch = '0; cfg_src = '0; bypass_phase = 1;
        cell_clk = 1'b0; in_pin = 4'b1010; io_pad_in = 4'b0101;
        cycle(1, "");
        cell_clk = 1'b1; cycle(1, "");
        cell_clk = 1'b0; cfg_bypass = '1; in_pin = 4'b0101; io_pad_in = 4'b1010;
        cycle(1, "R4");
        cell_clk = 1'b1; cycle(1, "R4");
        cfg_bypass = '0; cell_clk = 1'b0;
        cycle(1, "R4");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule